// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers twelve interrupt request lines for a small processor core and offers the sequencer one request at a time, together with a fixed 16-bit word vector. Each line is synchronized, then either latched on its rising edge or taken as a live level. A mask register, a global enable and a one-cycle hold-off after every mask write gate the lines. A fixed priority order picks the winner. Software can set or clear latched requests through a write-only force/clear port. A control register selects the sensing of three external lines and turns nesting on or off.

The sequencer takes a request by raising `irq_ready` while `irq_valid` is high. That handshake clears the source's latch and records the source as in service. A `rti` strobe retires the most recent (highest-priority) in-service record. With nesting off, nothing but the restart source is offered while any record is open. With nesting on, only a source of strictly higher priority than every open record is offered. The offer follows interrupt semantics, not stream semantics. While `irq_ready` is low, a pending request stays offered and its latch is kept. The offered id and vector always name the current best candidate, so a higher-priority arrival replaces the offer before it is taken. A mask, enable or hold-off change can also withdraw the offer.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `irq_valid` is 0, all mask bits are 0 (every maskable source masked), global enable is on, nesting is off and the three configurable lines are level-sensitive.
- R2: Source index sets the priority, with index 0 the highest. The vectors are: 0 restart 0x0000, 1 power-down 0x002C, 2 external line C 0x0004, 3 level line B 0x0008, 4 level line A 0x000C, 5 serial-0 send 0x0010, 6 serial-0 receive 0x0014, 7 forceable edge line 0x0018, 8 DMA done 0x001C, 9 serial-1 send / external line B 0x0020, 10 serial-1 receive / external line A 0x0024, 11 timer 0x0028. The lowest eligible index is offered on `irq_id` / `irq_vector`.
- R3: A source with index of 2 or more is eligible only while mask bit i (`mask_wdata[i]`, 1 = enabled) is 1. The power-down source (index 1) ignores the mask.
- R4: In the cycle after a `mask_wr` edge, no source other than index 0 is offered.
- R5: `gie_clr` turns the global enable off, and `gie_set` turns it on (set wins if both are raised). While the enable is off, no source other than index 0 is offered, power-down included.
- R6: Edge sources latch a rising edge of the synchronized input. The latch holds after the input drops and clears when that source is taken (`irq_valid && irq_ready`).
- R7: Indices 3 and 4 are always level-sensitive. They are pending only while their input is high and leave nothing behind.
- R8: `ctl_wdata` bit 0 selects index 10, bit 1 index 9 and bit 2 index 2 (1 = edge, 0 = level). Every other source except 3 and 4 is always edge-sensitive.
- R9: A `fc_wr` strobe sets the latches named in `fc_set` and clears those named in `fc_clr`. It has no effect on a source in level mode. A rising edge in the same cycle as a clear leaves the latch set.
- R10: `ctl_wdata` bit 3 enables nesting. When nesting is off, nothing but index 0 is offered while any record is open. When nesting is on, only an index lower than every open record is offered. `rti` retires the open record with the lowest index.
- R11: Index 0 ignores the mask, the enable, the hold-off and the nesting rules. Taking it closes every open record.
- R12: While `irq_ready` is low, a pending offered request stays offered with its latch kept. A higher-priority arrival replaces the offered id and vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_in | input | 12 | Raw request lines, bit i = source i |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 12 | New mask, 1 enables the source |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Bits 0-2 line sensing, bit 3 nesting enable |
| fc_wr | input | 1 | Force/clear strobe |
| fc_set | input | 12 | Latches to set |
| fc_clr | input | 12 | Latches to clear |
| gie_set | input | 1 | Global enable on |
| gie_clr | input | 1 | Global enable off |
| irq_valid | output | 1 | A request is offered |
| irq_ready | input | 1 | Sequencer takes the offered request |
| irq_id | output | 4 | Offered source index |
| irq_vector | output | 16 | Offered vector address |
| rti | input | 1 | Return-from-interrupt strobe |

## Verification
The bench aims at a clear that lands in the same cycle as a fresh edge. A design that let the clear win would lose an interrupt. It writes the mask while a level request is high and samples in the hold-off cycle. A design without the hold-off would offer the request one cycle early. Nested returns are checked pop by pop. Popping the wrong record, or letting equal priority preempt, would expose a lower-priority request too soon. The bench also holds `irq_ready` low while a higher request arrives, so a design that froze its first offer, or dropped latches it had not delivered, shows the wrong vector. Power-down and restart requests are driven with the mask cleared and the enable off, which separates the two kinds of nonmaskable behaviour.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NSRC  = 12;
  localparam int IDW   = $clog2(NSRC);
  localparam int VECW  = 16;
  localparam int CTLW  = 4;

  // source indices whose handling differs from a plain edge line
  localparam int SRC_RESTART = 0;
  localparam int SRC_PWRDN   = 1;
  localparam int SRC_EXTC    = 2;
  localparam int SRC_LVLB    = 3;
  localparam int SRC_LVLA    = 4;
  localparam int SRC_EXTB    = 9;
  localparam int SRC_EXTA    = 10;

  // control register bit positions
  localparam int CTL_EXTA_EDGE = 0;
  localparam int CTL_EXTB_EDGE = 1;
  localparam int CTL_EXTC_EDGE = 2;
  localparam int CTL_NEST      = 3;

  function automatic logic [VECW-1:0] vector_of(input logic [IDW-1:0] id);
    if (id == IDW'(SRC_RESTART))    return '0;
    else if (id == IDW'(SRC_PWRDN)) return VECW'(16'h002C);
    else                            return VECW'({id - IDW'(1), 2'b00});
  endfunction
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
  parameter int N      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] sh;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh   <= '0;
        prev <= 1'b0;
      end else begin
        sh   <= {sh[STAGES-2:0], din[g]};
        prev <= sh[STAGES-1];
      end
    end
    assign lvl[g]  = sh[STAGES-1];
    assign rise[g] = sh[STAGES-1] & ~prev;
  end
endmodule

// File: rtl/vic_pend.sv
module vic_pend #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] rise,
  input  logic [N-1:0] edge_mode,
  input  logic         fc_wr,
  input  logic [N-1:0] fc_set,
  input  logic [N-1:0] fc_clr,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] pend
);
  for (genvar g = 0; g < N; g++) begin : g_src
    logic lat;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 lat <= 1'b0;
      else if (!edge_mode[g])                     lat <= 1'b0;
      else if (rise[g])                           lat <= 1'b1;
      else if (fc_wr && fc_set[g])                lat <= 1'b1;
      else if ((fc_wr && fc_clr[g]) || ack_clr[g]) lat <= 1'b0;
    end
    assign pend[g] = edge_mode[g] ? lat : lvl[g];

    // a fresh edge is never lost to a simultaneous clear or acknowledge
    assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rise[g] && edge_mode[g]) |=> (lat || !edge_mode[g]));
  end
endmodule

// File: rtl/vic_select.sv
module vic_select
  import vic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] mask,
  input  logic            gie,
  input  logic            supp,
  input  logic            nest_en,
  input  logic [NSRC-1:0] insvc,
  output logic            valid,
  output logic [IDW-1:0]  id
);
  logic [NSRC-1:0] elig;

  always_comb begin
    logic acc;
    logic blocked;
    acc = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      acc     = acc | insvc[i];
      blocked = nest_en ? acc : (|insvc);
      if (i == SRC_RESTART)
        elig[i] = pend[i];
      else
        elig[i] = pend[i] & (mask[i] | (i == SRC_PWRDN)) & gie & ~supp & ~blocked;
    end
  end

  always_comb begin
    valid = 1'b0;
    id    = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        valid = 1'b1;
        id    = IDW'(i);
      end
    end
  end

  assert_mask_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && id > IDW'(SRC_PWRDN)) |-> mask[id]);
  assert_offer_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> pend[id]);
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_in,
  input  logic            mask_wr,
  input  logic [NSRC-1:0] mask_wdata,
  input  logic            ctl_wr,
  input  logic [CTLW-1:0] ctl_wdata,
  input  logic            fc_wr,
  input  logic [NSRC-1:0] fc_set,
  input  logic [NSRC-1:0] fc_clr,
  input  logic            gie_set,
  input  logic            gie_clr,
  output logic            irq_valid,
  input  logic            irq_ready,
  output logic [IDW-1:0]  irq_id,
  output logic [VECW-1:0] irq_vector,
  input  logic            rti
);
  logic [NSRC-1:0] mask_q, insvc_q, edge_mode, lvl, rise, pend, ack_clr, pop_bit;
  logic [CTLW-1:0] ctl_q;
  logic            gie_q, supp_q, take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ctl_q  <= '0;
      gie_q  <= 1'b1;
      supp_q <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= mask_wdata;
      if (ctl_wr)  ctl_q  <= ctl_wdata;
      supp_q <= mask_wr;
      if (gie_set)      gie_q <= 1'b1;
      else if (gie_clr) gie_q <= 1'b0;
    end
  end

  always_comb begin
    edge_mode            = '1;
    edge_mode[SRC_LVLB]  = 1'b0;
    edge_mode[SRC_LVLA]  = 1'b0;
    edge_mode[SRC_EXTC]  = ctl_q[CTL_EXTC_EDGE];
    edge_mode[SRC_EXTB]  = ctl_q[CTL_EXTB_EDGE];
    edge_mode[SRC_EXTA]  = ctl_q[CTL_EXTA_EDGE];
  end

  vic_sync #(.N(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(req_in), .lvl(lvl), .rise(rise)
  );

  assign take    = irq_valid & irq_ready;
  assign ack_clr = take ? (NSRC'(1) << irq_id) : '0;

  vic_pend #(.N(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise), .edge_mode(edge_mode),
    .fc_wr(fc_wr), .fc_set(fc_set), .fc_clr(fc_clr), .ack_clr(ack_clr), .pend(pend)
  );

  vic_select u_sel (
    .clk(clk), .rst_n(rst_n), .pend(pend), .mask(mask_q), .gie(gie_q),
    .supp(supp_q), .nest_en(ctl_q[CTL_NEST]), .insvc(insvc_q),
    .valid(irq_valid), .id(irq_id)
  );

  assign irq_vector = vector_of(irq_id);

  // in-service record: lowest index is always the newest open level
  assign pop_bit = rti ? (insvc_q & (~insvc_q + NSRC'(1))) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) insvc_q <= '0;
    else if (take && irq_id == IDW'(SRC_RESTART)) insvc_q <= '0;
    else insvc_q <= (insvc_q & ~pop_bit) | ack_clr;
  end

  assert_holdoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (!irq_valid || irq_id == IDW'(SRC_RESTART)));
  assert_gie_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_id != IDW'(SRC_RESTART)) |-> gie_q);
  assert_sequential_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[CTL_NEST] && (|insvc_q) && irq_valid) |-> irq_id == IDW'(SRC_RESTART));
  assert_restart_close_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && irq_id == IDW'(SRC_RESTART)) |=> insvc_q == '0);
endmodule

// File: tb/vec_irq_ctrl_bench.sv
module vec_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [11:0] req = '0, mask_wdata = '0, fc_set = '0, fc_clr = '0;
  logic        mask_wr = 0, ctl_wr = 0, fc_wr = 0, gie_set = 0, gie_clr = 0;
  logic        irq_ready = 0, rti = 0, irq_valid;
  logic [3:0]  ctl_wdata = '0, irq_id;
  logic [15:0] irq_vector;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_ctrl u_vec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_in(req), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .fc_wr(fc_wr), .fc_set(fc_set), .fc_clr(fc_clr),
    .gie_set(gie_set), .gie_clr(gie_clr), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_id(irq_id), .irq_vector(irq_vector), .rti(rti)
  );

  function automatic int exp_vec(int id);
    case (id)
      0: return 'h0000;  1: return 'h002C;  2: return 'h0004;  3: return 'h0008;
      4: return 'h000C;  5: return 'h0010;  6: return 'h0014;  7: return 'h0018;
      8: return 'h001C;  9: return 'h0020; 10: return 'h0024; 11: return 'h0028;
      default: return -1;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_none(string tag);
    chk(irq_valid == 0, tag, "valid", int'(irq_valid), 0);
  endtask

  task automatic expect_src(int id, string tag);
    chk(irq_valid == 1, tag, "valid", int'(irq_valid), 1);
    chk(int'(irq_id) == id, tag, "id", int'(irq_id), id);
    chk(int'(irq_vector) == exp_vec(id), tag, "vector", int'(irq_vector), exp_vec(id));
  endtask

  task automatic pulse(int idx);
    req[idx] = 1; tick(1); req[idx] = 0;
  endtask
  task automatic wr_mask(logic [11:0] m);
    mask_wr = 1; mask_wdata = m; tick(1); mask_wr = 0;
  endtask
  task automatic wr_ctl(logic [3:0] c);
    ctl_wr = 1; ctl_wdata = c; tick(1); ctl_wr = 0;
  endtask
  task automatic accept();
    irq_ready = 1; tick(1); irq_ready = 0;
  endtask
  task automatic ret();
    rti = 1; tick(1); rti = 0;
  endtask
  task automatic force_clear(logic [11:0] s, logic [11:0] c);
    fc_wr = 1; fc_set = s; fc_clr = c; tick(1); fc_wr = 0; fc_set = '0; fc_clr = '0;
  endtask

  task automatic t_reset();
    tick(1);
    expect_none("R1");
    req[3] = 1; tick(4);
    expect_none("R1");               // mask resets to all masked
  endtask

  task automatic t_mask_holdoff();
    wr_mask(12'hFFF);
    expect_none("R4");               // hold-off cycle
    tick(1);
    expect_src(3, "R2");
    wr_mask(12'hFFF & ~12'h008);
    expect_none("R4");
    tick(1);
    expect_none("R3");
    wr_mask(12'hFFF); tick(1);
    expect_src(3, "R3");
    req[3] = 0; tick(3);
    expect_none("R7");
    req[4] = 1; tick(3);
    expect_src(4, "R7");
    req[4] = 0; tick(3);
    expect_none("R7");
  endtask

  task automatic t_priority();
    pulse(11); pulse(8); pulse(5); tick(4);
    expect_src(5, "R2");
    accept();
    expect_none("R10");
    ret();
    expect_src(8, "R6");
    accept(); ret();
    expect_src(11, "R6");
    accept(); ret();
    expect_none("R6");
  endtask

  task automatic t_nonmaskable();
    wr_mask(12'h000); tick(1);
    pulse(1); tick(4);
    expect_src(1, "R3");
    gie_clr = 1; tick(1); gie_clr = 0;
    expect_none("R5");
    pulse(0); tick(4);
    expect_src(0, "R11");
    accept();
    expect_none("R5");
    gie_set = 1; tick(1); gie_set = 0;
    expect_src(1, "R5");
    accept(); ret();
    expect_none("R6");
  endtask

  task automatic t_ext_sense();
    wr_mask(12'hFFF);
    req[2] = 1; tick(3);
    expect_src(2, "R8");
    req[2] = 0; tick(3);
    expect_none("R8");
    wr_ctl(4'b0100);
    pulse(2); tick(4);
    expect_src(2, "R8");
    accept(); ret();
    expect_none("R8");
  endtask

  task automatic t_force();
    force_clear(12'h080, 12'h000);
    expect_src(7, "R9");
    force_clear(12'h000, 12'h080);
    expect_none("R9");
    force_clear(12'h008, 12'h000);   // level source: force ignored
    expect_none("R9");
    req[8] = 1; tick(1); req[8] = 0; tick(1);
    force_clear(12'h000, 12'h100);
    expect_src(8, "R9");             // edge beats clear
    accept(); ret();
  endtask

  task automatic t_nest();
    pulse(11); tick(4);
    expect_src(11, "R10");
    accept();
    pulse(5); tick(4);
    expect_none("R10");
    ret();
    expect_src(5, "R10");
    wr_ctl(4'b1100);
    accept();
    pulse(11); tick(4);
    expect_none("R10");
    pulse(1); tick(4);
    expect_src(1, "R10");
    accept();
    expect_none("R10");
    ret();
    expect_none("R10");
    ret();
    expect_src(11, "R10");
    accept(); ret();
    expect_none("R10");
  endtask

  task automatic t_restart();
    wr_ctl(4'b0100);
    pulse(11); tick(4); accept();
    pulse(0); tick(4);
    expect_src(0, "R11");
    accept();
    pulse(6); tick(4);
    expect_src(6, "R11");
    accept(); ret();
  endtask

  task automatic t_backpressure();
    pulse(11); tick(4);
    expect_src(11, "R12");
    tick(3);
    expect_src(11, "R12");
    pulse(5); tick(4);
    expect_src(5, "R12");
    accept(); ret();
    expect_src(11, "R12");
    accept(); ret();
    expect_none("R12");
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    t_reset();
    t_mask_holdoff();
    t_priority();
    t_nonmaskable();
    t_ext_sense();
    t_force();
    t_nest();
    t_restart();
    t_backpressure();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule